// File: doc/BRIEF.md
# Graphics Window Line Scanner

This block turns one rectangular graphics layer into a list of per-line copy jobs. Software places the window at an X/Y position on a panel and gives both sizes, a pixel-format code, and source and destination base addresses. When `start` arrives, the scanner first decides whether the frame may be drawn at all. If it may, it clips the window to the panel and then issues one request per line. Each request carries a source byte address, a destination byte address and a byte length. A copy engine downstream consumes the requests through a valid/ready handshake.

The source side always steps by the full window line, even when the right edge is clipped, so the clipped part of each source line is skipped. The destination side starts at the window origin inside the panel and steps by the destination line pitch. A frame ends with a one-cycle `done`. If the frame was refused, `done` comes with an error flag that names the reason.

Top module: `gfx_window_scanner`

## Requirements
- R1: After reset, `req_valid`, `done`, `rot_err` and `fmt_err` are all 0.
- R2: A frame produces no requests and no error flag, only `done` one cycle after `start`, unless all of these hold: `out_enable`=1, `out_active`=1, `remote_mode`=0, channel-select attribute bit 8 = 0, and layer-enable attribute bit 0 = 1.
- R3: If the frame passes R2 and attribute bits 13:12 are nonzero (rotation requested), no requests are made. `done` and `rot_err` pulse together one cycle after `start`. This check takes priority over R4.
- R4: Bytes per pixel come from attribute bits 4:1. Code 0x6 gives 2, 0x8 gives 4, 0x9 gives 3 and 0xE gives 4. Any other code makes no requests, and `done` and `fmt_err` pulse together one cycle after `start`.
- R5: The copy width is `panel_w - pos_x` when `pos_x + win_w > panel_w`, and `win_w` otherwise. It is 0 when `pos_x >= panel_w`. `req_len` equals the copy width times bytes per pixel.
- R6: The number of line requests equals min(`win_h`, `panel_h`). A copy width or copy height of 0 gives no requests, only `done`.
- R7: The first `req_src` is `src_base`. Each following line adds `win_w` times bytes per pixel, whatever the clipping.
- R8: The first `req_dst` is `dst_base + pos_y*dst_pitch + pos_x*dst_bpp`. Each following line adds `dst_pitch`.
- R9: While `req_valid`=1 and `req_ready`=0, all request fields hold their values. One line is accepted on each cycle in which both are 1.
- R10: `done` rises in the cycle after the last accepted line, with `req_valid` low. A `start` arriving while lines are still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| out_enable | input | 1 | Output path enabled |
| out_active | input | 1 | Output path active |
| remote_mode | input | 1 | Remote-framebuffer mode selected; blocks scanning |
| layer_attr | input | 16 | Layer attributes: bit0 enable, bits4:1 format, bit8 channel, bits13:12 rotation |
| panel_w | input | CW | Panel width in pixels |
| panel_h | input | CW | Panel height in lines |
| pos_x | input | CW | Window X position |
| pos_y | input | CW | Window Y position |
| win_w | input | CW | Window width in pixels |
| win_h | input | CW | Window height in lines |
| src_base | input | AW | Source byte address of window line 0 |
| dst_base | input | AW | Destination byte address of panel origin |
| dst_pitch | input | PW | Destination line size in bytes |
| dst_bpp | input | 3 | Destination bytes per pixel |
| req_ready | input | 1 | Copy engine accepts the current request |
| req_valid | output | 1 | Line request valid |
| req_src | output | AW | Source byte address of the line |
| req_dst | output | AW | Destination byte address of the line |
| req_len | output | CW+3 | Bytes to copy for the line |
| done | output | 1 | One-cycle end-of-frame strobe |
| rot_err | output | 1 | Frame refused for rotation, pulses with done |
| fmt_err | output | 1 | Frame refused for unknown format, pulses with done |

## Verification
The in-line assertions check on every cycle that request fields hold still while stalled. They also check that `done` never overlaps a pending request, that error flags appear only with `done` and never both at once, and that a valid request never has zero length or a zero line count behind it. The clipping arithmetic, the format table, the address sequences and the gating and priority order are shown only by the bench. It sweeps many panel, position, size and format combinations, with and without back-pressure, and compares every accepted line against independently computed addresses and lengths.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wsc_state_e;

  // source bytes per pixel for a format code, 0 when the code is undefined
  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    logic [2:0] b;
    case (code)
      4'h6:    b = 3'd2;
      4'h8:    b = 3'd4;
      4'h9:    b = 3'd3;
      4'hE:    b = 3'd4;
      default: b = 3'd0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/wsc_fmt_decode.sv
module wsc_fmt_decode
  import wsc_pkg::*;
(
  input  logic [15:0] attr,
  output logic        layer_en,
  output logic        chan_sel,
  output logic        rot_bad,
  output logic        fmt_bad,
  output logic [2:0]  bpp
);
  always_comb begin
    layer_en = attr[0];
    chan_sel = attr[8];
    rot_bad  = |attr[13:12];
    bpp      = fmt_bytes(attr[4:1]);
    fmt_bad  = (bpp == 3'd0);
  end
endmodule

// File: rtl/wsc_clip.sv
module wsc_clip #(
  parameter int CW = 11
) (
  input  logic [CW-1:0] panel_w,
  input  logic [CW-1:0] panel_h,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  output logic [CW-1:0] copy_w,
  output logic [CW-1:0] copy_h
);
  logic [CW:0] right_edge;

  always_comb begin
    right_edge = {1'b0, pos_x} + {1'b0, win_w};
    if (pos_x >= panel_w)
      copy_w = '0;
    else if (right_edge > {1'b0, panel_w})
      copy_w = panel_w - pos_x;
    else
      copy_w = win_w;
    copy_h = (win_h < panel_h) ? win_h : panel_h;
  end
endmodule

// File: rtl/wsc_addr_step.sv
module wsc_addr_step #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] init_val,
  input  logic [SW-1:0] step,
  output logic [AW-1:0] addr
);
  logic [SW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      step_q <= '0;
    end else if (load) begin
      addr   <= init_val;
      step_q <= step;
    end else if (advance) begin
      addr   <= addr + AW'(step_q);
    end
  end
endmodule

// File: rtl/gfx_window_scanner.sv
module gfx_window_scanner
  import wsc_pkg::*;
#(
  parameter int CW = 11,
  parameter int AW = 32,
  parameter int PW = 16,
  localparam int LW = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          out_enable,
  input  logic          out_active,
  input  logic          remote_mode,
  input  logic [15:0]   layer_attr,
  input  logic [CW-1:0] panel_w,
  input  logic [CW-1:0] panel_h,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [PW-1:0] dst_pitch,
  input  logic [2:0]    dst_bpp,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [LW-1:0] req_len,
  output logic          done,
  output logic          rot_err,
  output logic          fmt_err
);
  wsc_state_e    state;
  logic [CW-1:0] lines_left;

  logic          layer_en, chan_sel, rot_bad, fmt_bad;
  logic [2:0]    bpp;
  logic [CW-1:0] copy_w, copy_h;

  wsc_fmt_decode u_fmt (
    .attr     (layer_attr),
    .layer_en (layer_en),
    .chan_sel (chan_sel),
    .rot_bad  (rot_bad),
    .fmt_bad  (fmt_bad),
    .bpp      (bpp)
  );

  wsc_clip #(.CW(CW)) u_clip (
    .panel_w (panel_w),
    .panel_h (panel_h),
    .pos_x   (pos_x),
    .win_w   (win_w),
    .win_h   (win_h),
    .copy_w  (copy_w),
    .copy_h  (copy_h)
  );

  logic          go, gate_ok, fire, last_fire, run_ok;
  logic [LW-1:0] src_step, line_len;
  logic [AW-1:0] dst_first;

  always_comb begin
    go        = start && (state == ST_IDLE);
    gate_ok   = out_enable && out_active && !remote_mode && !chan_sel && layer_en;
    run_ok    = gate_ok && !rot_bad && !fmt_bad && (copy_w != '0) && (copy_h != '0);
    src_step  = LW'(win_w) * LW'(bpp);
    line_len  = LW'(copy_w) * LW'(bpp);
    dst_first = dst_base + AW'(pos_y) * AW'(dst_pitch) + AW'(pos_x) * AW'(dst_bpp);
    fire      = req_valid && req_ready;
    last_fire = fire && (lines_left == CW'(1));
  end

  wsc_addr_step #(.AW(AW), .SW(LW)) u_src (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .advance  (fire && !last_fire),
    .init_val (src_base),
    .step     (src_step),
    .addr     (req_src)
  );

  wsc_addr_step #(.AW(AW), .SW(PW)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .advance  (fire && !last_fire),
    .init_val (dst_first),
    .step     (dst_pitch),
    .addr     (req_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lines_left <= '0;
      req_valid  <= 1'b0;
      req_len    <= '0;
      done       <= 1'b0;
      rot_err    <= 1'b0;
      fmt_err    <= 1'b0;
    end else begin
      done    <= 1'b0;
      rot_err <= 1'b0;
      fmt_err <= 1'b0;
      if (go) begin
        if (run_ok) begin
          state      <= ST_RUN;
          req_valid  <= 1'b1;
          req_len    <= line_len;
          lines_left <= copy_h;
        end else begin
          done    <= 1'b1;
          rot_err <= gate_ok && rot_bad;
          fmt_err <= gate_ok && !rot_bad && fmt_bad;
        end
      end else if (fire) begin
        if (last_fire) begin
          state     <= ST_IDLE;
          req_valid <= 1'b0;
          done      <= 1'b1;
        end
        lines_left <= lines_left - CW'(1);
      end
    end
  end

  // R9: a stalled request keeps every field
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len));

  // R10: done never overlaps a pending request
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  // R10: accepting the last line raises done next
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (lines_left == CW'(1)) |=> done && !req_valid);

  // R3: rotation error only with done, never alongside format error
  a_r3_rot_with_done: assert property (@(posedge clk) disable iff (rst)
    rot_err |-> done && !fmt_err);

  // R4: format error only with done
  a_r4_fmt_with_done: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> done);

  // R5 and R6: a live request has bytes to move and lines left
  a_r6_live_request: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && (lines_left != '0));
endmodule

// File: tb/gfx_window_scanner_bench.sv
module gfx_window_scanner_bench;
  localparam int CW = 11;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int LW = CW + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          out_enable = 1'b1, out_active = 1'b1, remote_mode = 1'b0;
  logic [15:0]   layer_attr = '0;
  logic [CW-1:0] panel_w = '0, panel_h = '0, pos_x = '0, pos_y = '0, win_w = '0, win_h = '0;
  logic [AW-1:0] src_base = 32'h8000, dst_base = 32'h1000;
  logic [PW-1:0] dst_pitch = '0;
  logic [2:0]    dst_bpp = 3'd4;
  logic          req_ready = 1'b1;
  logic          req_valid, done, rot_err, fmt_err;
  logic [AW-1:0] req_src, req_dst;
  logic [LW-1:0] req_len;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  gfx_window_scanner #(.CW(CW), .AW(AW), .PW(PW)) u_gfx_window_scanner (
    .clk(clk), .rst(rst), .start(start),
    .out_enable(out_enable), .out_active(out_active), .remote_mode(remote_mode),
    .layer_attr(layer_attr),
    .panel_w(panel_w), .panel_h(panel_h), .pos_x(pos_x), .pos_y(pos_y),
    .win_w(win_w), .win_h(win_h),
    .src_base(src_base), .dst_base(dst_base), .dst_pitch(dst_pitch), .dst_bpp(dst_bpp),
    .req_ready(req_ready), .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .req_len(req_len), .done(done), .rot_err(rot_err), .fmt_err(fmt_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic int exp_bpp(input int code);
    if (code == 6) return 2;
    if (code == 8 || code == 14) return 4;
    if (code == 9) return 3;
    return 0;
  endfunction

  // one frame: gate bits, attribute, geometry; stall selects back-pressure, poke re-issues start mid-frame
  task automatic run_frame(input string tag, input bit en, input bit act, input bit rem,
                           input logic [15:0] attr, input int pw, input int ph, input int px,
                           input int py, input int ww, input int wh, input bit stall, input bit poke);
    int bpp, cw, chh, lines_e, seen, it;
    bit gate, exp_rot, exp_fmt, got_done;
    out_enable = en; out_active = act; remote_mode = rem; layer_attr = attr;
    panel_w = CW'(pw); panel_h = CW'(ph); pos_x = CW'(px); pos_y = CW'(py);
    win_w = CW'(ww); win_h = CW'(wh); dst_pitch = PW'(pw * 4); dst_bpp = 3'd4;
    bpp  = exp_bpp(int'(attr[4:1]));
    gate = en && act && !rem && !attr[8] && attr[0];
    exp_rot = gate && (attr[13:12] != 2'b00);
    exp_fmt = gate && !exp_rot && (bpp == 0);
    if (px >= pw) cw = 0; else if (px + ww > pw) cw = pw - px; else cw = ww;
    chh = (wh < ph) ? wh : ph;
    lines_e = (gate && !exp_rot && !exp_fmt) ? ((cw == 0) ? 0 : chh) : 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0; got_done = 0;
    for (it = 0; it < 400 && !got_done; it++) begin
      if (poke && it == 2) begin start = 1'b1; pos_x = CW'(0); win_w = CW'(1); end
      else start = 1'b0;
      req_ready = stall ? ((it % 3) != 1) : 1'b1;
      if (done) begin
        got_done = 1;
        vectors++;
        if (seen != lines_e || rot_err != exp_rot || fmt_err != exp_fmt || req_valid) begin
          errors++;
          $display("FAIL %s: lines/rot/fmt/valid actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/0",
                   tag, seen, rot_err, fmt_err, req_valid, lines_e, exp_rot, exp_fmt);
        end
      end else if (req_valid && req_ready) begin
        longint es, ed, el;
        es = longint'(src_base) + longint'(seen) * ww * bpp;
        ed = longint'(dst_base) + longint'(py) * pw * 4 + px * 4 + longint'(seen) * pw * 4;
        el = cw * bpp;
        vectors++;
        if (longint'(req_src) != es || longint'(req_dst) != ed || longint'(req_len) != el) begin
          errors++;
          $display("FAIL %s R5/R7/R8 line %0d: src/dst/len actual %0h/%0h/%0d expected %0h/%0h/%0d",
                   tag, seen, req_src, req_dst, req_len, es, ed, el);
        end
        seen++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    req_ready = 1'b1;
    if (!got_done) begin
      errors++;
      $display("FAIL %s R10: done actual never expected after %0d lines", tag, lines_e);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    vectors++;
    if (req_valid || done || rot_err || fmt_err) begin
      errors++;
      $display("FAIL R1: valid/done/rot/fmt actual %0b%0b%0b%0b expected 0000", req_valid, done, rot_err, fmt_err);
    end

    // R2: each gate condition alone blocks the frame
    run_frame("R2_enable",  0, 1, 0, 16'h0011, 8, 6, 0, 0, 4, 3, 0, 0);
    run_frame("R2_active",  1, 0, 0, 16'h0011, 8, 6, 0, 0, 4, 3, 0, 0);
    run_frame("R2_remote",  1, 1, 1, 16'h0011, 8, 6, 0, 0, 4, 3, 0, 0);
    run_frame("R2_channel", 1, 1, 0, 16'h0111, 8, 6, 0, 0, 4, 3, 0, 0);
    run_frame("R2_layer",   1, 1, 0, 16'h0010, 8, 6, 0, 0, 4, 3, 0, 0);
    // R2 wins over rotation and bad format
    run_frame("R2_prio",    0, 1, 0, 16'h3001, 8, 6, 0, 0, 4, 3, 0, 0);

    // R3: every nonzero rotation, also over a bad format code
    for (int r = 1; r < 4; r++)
      run_frame("R3_rot", 1, 1, 0, 16'h0011 | 16'(r << 12), 8, 6, 1, 1, 4, 3, 0, 0);
    run_frame("R3_over_R4", 1, 1, 0, 16'h1001, 8, 6, 1, 1, 4, 3, 0, 0);

    // R4: all sixteen format codes
    for (int c = 0; c < 16; c++)
      run_frame("R4_fmt", 1, 1, 0, 16'h0001 | 16'(c << 1), 8, 6, 2, 1, 5, 3, c[0], 0);

    // R6: zero width window, window beyond right edge, zero height
    run_frame("R6_zero_w", 1, 1, 0, 16'h0011, 8, 6, 0, 0, 0, 3, 0, 0);
    run_frame("R6_off_right", 1, 1, 0, 16'h0011, 8, 6, 9, 0, 4, 3, 0, 0);
    run_frame("R6_zero_h", 1, 1, 0, 16'h0011, 8, 6, 0, 0, 4, 0, 0, 0);

    // R10: start while lines are pending is ignored
    run_frame("R10_busy_start", 1, 1, 0, 16'h0013, 8, 6, 3, 2, 4, 5, 1, 1);

    // R5 R6 R7 R8 R9: geometry sweep with and without back-pressure
    foreach (exp_bpp_codes[i]) begin end
    for (int fi = 0; fi < 4; fi++) begin
      int code;
      code = (fi == 0) ? 6 : (fi == 1) ? 8 : (fi == 2) ? 9 : 14;
      for (int pw = 4; pw <= 7; pw += 3)
        for (int ph = 3; ph <= 5; ph += 2)
          for (int px = 0; px < 9; px += 2)
            for (int py = 0; py < 2; py++)
              for (int ww = 1; ww <= 7; ww += 3)
                for (int wh = 2; wh <= 6; wh += 4)
                  run_frame("R5_R9_sweep", 1, 1, 0, 16'h0001 | 16'(code << 1),
                            pw, ph, px, py, ww, wh, ((px + ww) % 2) == 1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  int exp_bpp_codes [1] = '{0};
endmodule